// File: doc/BRIEF.md
# NOR Flash Command Controller

This block is a clocked model of the command front end and embedded-operation engine of a parallel NOR flash. It holds a small internal array split into equal sectors. Host bus cycles arrive on active-low chip enable, write enable and output enable lines with an address and a data byte. All of them are sampled on the clock. A write cycle is counted once, on the first clock where chip enable and write enable are low and output enable is high. A read cycle is counted once, on the first clock where chip enable and output enable are low and write enable is high.

Write cycles are decoded into unlock sequences, program, sector erase, bypass entry and exit, and reset. An accepted program or erase runs as a timed embedded operation. The ready output is low for the whole of that operation. Reads made during the operation return a status byte in place of array data. Per-sector protection flags and a low-supply input gate every change to the array.

Top module: `norCmdEngine`

## Requirements
- R1: After reset, ready is high and every array location reads 0xFF.
- R2: Four writes program one location: 0xAA to address 0x555, 0x55 to address 0x2AA, 0xA0 to any address, then the data byte to the target address. The stored value becomes the old value ANDed with the written value.
- R3: Ready goes low on the clock that accepts the final write of a program or erase. It stays low for exactly PGM_CYC cycles for a program, and for PRE_CYC plus ERS_CYC cycles for an erase.
- R4: A read during a program returns the complement of the written bit 7 on bit 7. A read during an erase returns 0 on bit 7. Once ready is high again, a read returns the array content.
- R5: During an embedded operation, bit 6 of the read data alternates between successive reads. After completion, repeated reads of a location return identical data.
- R6: A sector erase is 0xAA@0x555, 0x55@0x2AA, 0x80, 0xAA@0x555, 0x55@0x2AA, then 0x30 written to any address inside the sector. A preprogram phase is followed by an erase phase, which leaves every location of that sector at 0xFF. Other sectors keep their content.
- R7: 0xAA@0x555, 0x55@0x2AA, 0x20 enters bypass mode. In bypass mode, 0xA0 followed by the address and data programs a location in two writes. 0x90 followed by 0x00 leaves bypass mode. After that, a bare 0xA0 and data pair changes nothing.
- R8: Sector s is protected while protectMask bit s is 1. A program or erase aimed at a protected sector leaves its content unchanged, and ready stays high.
- R9: While lowSupply is 1, every write cycle is ignored: a full program sequence neither starts an operation nor changes the array.
- R10: A write that does not fit the sequence in progress aborts it and returns to read mode. 0xF0 counts as such a write. A data write that follows an abort changes nothing.
- R11: Write cycles made while an embedded operation runs are ignored. Decoding resumes in read mode once ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Bus address; low bits select the array word, top of those bits the sector |
| dataIn | input | DATA_W | Write data / command byte |
| protectMask | input | SECTORS | One protection flag per sector |
| lowSupply | input | 1 | Low-supply lockout, blocks all writes |
| dataOut | output | DATA_W | Read data or status byte, updated on each read cycle start |
| ready | output | 1 | High when no embedded operation is running |

## Verification
A host read or write can arrive on the same clock as a running program or erase. Such a read must come back as status rather than array data. Such a write must be dropped by the decoder and must not corrupt the latched operand. The bench provokes both by issuing reads and a partial command sequence while ready is low. It judges the outcome from the polling and toggle bits, from the busy length, and from the array contents read back after ready returns.

// File: rtl/nfcPkg.sv
package nfcPkg;

  localparam logic [7:0]  CMD_KEY1     = 8'hAA;
  localparam logic [7:0]  CMD_KEY2     = 8'h55;
  localparam logic [7:0]  CMD_PROGRAM  = 8'hA0;
  localparam logic [7:0]  CMD_ERASE    = 8'h80;
  localparam logic [7:0]  CMD_SECTOR   = 8'h30;
  localparam logic [7:0]  CMD_BYPASS   = 8'h20;
  localparam logic [7:0]  CMD_BYP_OUT1 = 8'h90;
  localparam logic [7:0]  CMD_BYP_OUT2 = 8'h00;
  localparam logic [11:0] KEY1_ADDR    = 12'h555;
  localparam logic [11:0] KEY2_ADDR    = 12'h2AA;

  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_PGMDATA,
    ST_ERS1, ST_ERS2, ST_ERS3,
    ST_BYP, ST_BYPEXIT,
    ST_BUSYPGM, ST_BUSYPRE, ST_BUSYERS
  } ctlState_t;

  typedef struct packed {
    logic pgmCommit;
    logic preCommit;
    logic eraseCommit;
  } nfcStrobe_t;

endpackage

// File: rtl/nfcBusSample.sv
module nfcBusSample (
  input  logic clk,
  input  logic rstN,
  input  logic ceN,
  input  logic weN,
  input  logic oeN,
  output logic wrStart,
  output logic rdStart
);
  logic wrAct, rdAct, wrPrev, rdPrev;

  assign wrAct = !ceN && !weN && oeN;
  assign rdAct = !ceN && !oeN && weN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPrev <= 1'b0;
      rdPrev <= 1'b0;
    end else begin
      wrPrev <= wrAct;
      rdPrev <= rdAct;
    end
  end

  assign wrStart = wrAct && !wrPrev;
  assign rdStart = rdAct && !rdPrev;
endmodule

// File: rtl/nfcControl.sv
module nfcControl
  import nfcPkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int SECTORS      = 4,
  parameter int SECTOR_WORDS = 16,
  parameter int PGM_CYC      = 8,
  parameter int PRE_CYC      = 6,
  parameter int ERS_CYC      = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStart,
  input  logic              lowSupply,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [SECTORS-1:0] protectMask,
  output nfcStrobe_t        strobe,
  output logic [$clog2(SECTORS*SECTOR_WORDS)-1:0] opIdx,
  output logic [DATA_W-1:0] opData,
  output logic              busy,
  output logic              pollBit
);
  localparam int SEC_W = $clog2(SECTORS);
  localparam int IDX_W = $clog2(SECTORS*SECTOR_WORDS);
  localparam int MAXC  = (PGM_CYC > PRE_CYC) ? ((PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC)
                                             : ((PRE_CYC > ERS_CYC) ? PRE_CYC : ERS_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  ctlState_t state;
  logic [CNT_W-1:0] cnt;
  logic bypass;
  logic wrOk, isKey1, isKey2, tgtProt;
  logic [DATA_W-1:0] cmd;

  assign wrOk    = wrStart && !lowSupply;
  assign cmd     = dataIn;
  assign isKey1  = (cmd == DATA_W'(CMD_KEY1)) && (addr == ADDR_W'(KEY1_ADDR));
  assign isKey2  = (cmd == DATA_W'(CMD_KEY2)) && (addr == ADDR_W'(KEY2_ADDR));
  assign tgtProt = protectMask[addr[IDX_W-1 -: SEC_W]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_READ;
      cnt    <= '0;
      bypass <= 1'b0;
      opIdx  <= '0;
      opData <= '0;
    end else begin
      case (state)
        ST_BUSYPGM: begin
          if (cnt == '0) state <= bypass ? ST_BYP : ST_READ;
          else           cnt   <= cnt - 1'b1;
        end
        ST_BUSYPRE: begin
          if (cnt == '0) begin
            state <= ST_BUSYERS;
            cnt   <= CNT_W'(ERS_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_BUSYERS: begin
          if (cnt == '0) state <= ST_READ;
          else           cnt   <= cnt - 1'b1;
        end
        default: begin
          if (wrOk) begin
            case (state)
              ST_READ: state <= isKey1 ? ST_UNL1 : ST_READ;
              ST_UNL1: state <= isKey2 ? ST_UNL2 : ST_READ;
              ST_UNL2: begin
                if (cmd == DATA_W'(CMD_PROGRAM))     state <= ST_PGMDATA;
                else if (cmd == DATA_W'(CMD_ERASE))  state <= ST_ERS1;
                else if (cmd == DATA_W'(CMD_BYPASS)) begin
                  state  <= ST_BYP;
                  bypass <= 1'b1;
                end else state <= ST_READ;
              end
              ST_PGMDATA: begin
                opIdx  <= addr[IDX_W-1:0];
                opData <= dataIn;
                if (tgtProt) state <= bypass ? ST_BYP : ST_READ;
                else begin
                  state <= ST_BUSYPGM;
                  cnt   <= CNT_W'(PGM_CYC - 1);
                end
              end
              ST_ERS1: state <= isKey1 ? ST_ERS2 : ST_READ;
              ST_ERS2: state <= isKey2 ? ST_ERS3 : ST_READ;
              ST_ERS3: begin
                if (cmd == DATA_W'(CMD_SECTOR) && !tgtProt) begin
                  opIdx <= addr[IDX_W-1:0];
                  state <= ST_BUSYPRE;
                  cnt   <= CNT_W'(PRE_CYC - 1);
                end else state <= ST_READ;
              end
              ST_BYP: begin
                if (cmd == DATA_W'(CMD_PROGRAM))       state <= ST_PGMDATA;
                else if (cmd == DATA_W'(CMD_BYP_OUT1)) state <= ST_BYPEXIT;
              end
              ST_BYPEXIT: begin
                if (cmd == DATA_W'(CMD_BYP_OUT2)) begin
                  state  <= ST_READ;
                  bypass <= 1'b0;
                end else state <= ST_BYP;
              end
              default: state <= ST_READ;
            endcase
          end
        end
      endcase
    end
  end

  assign busy = (state == ST_BUSYPGM) || (state == ST_BUSYPRE) || (state == ST_BUSYERS);
  assign strobe.pgmCommit   = (state == ST_BUSYPGM) && (cnt == '0);
  assign strobe.preCommit   = (state == ST_BUSYPRE) && (cnt == '0);
  assign strobe.eraseCommit = (state == ST_BUSYERS) && (cnt == '0);
  assign pollBit = (state == ST_BUSYPGM) ? ~opData[DATA_W-1] : 1'b0;
endmodule

// File: rtl/nfcDatapath.sv
module nfcDatapath
  import nfcPkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SECTORS      = 4,
  parameter int SECTOR_WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  nfcStrobe_t        strobe,
  input  logic [$clog2(SECTORS*SECTOR_WORDS)-1:0] opIdx,
  input  logic [DATA_W-1:0] opData,
  input  logic [SECTORS-1:0] protectMask,
  input  logic              busy,
  input  logic              pollBit,
  input  logic              rdStart,
  input  logic [$clog2(SECTORS*SECTOR_WORDS)-1:0] rdIdx,
  output logic [DATA_W-1:0] dataOut
);
  localparam int WORDS = SECTORS * SECTOR_WORDS;
  localparam int SEC_W = $clog2(SECTORS);
  localparam int IDX_W = $clog2(WORDS);

  logic [DATA_W-1:0] mem [WORDS];
  logic [SECTORS-1:0] secHit;
  logic toggle;
  logic [SEC_W-1:0] opSec;

  assign opSec = opIdx[IDX_W-1 -: SEC_W];

  for (genvar s = 0; s < SECTORS; s++) begin : gSec
    assign secHit[s] = (opSec == SEC_W'(s)) && !protectMask[s];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      dataOut <= '0;
      toggle  <= 1'b0;
    end else begin
      if (strobe.pgmCommit && secHit[opSec])
        mem[opIdx] <= mem[opIdx] & opData;
      for (int i = 0; i < WORDS; i++) begin
        if (strobe.preCommit && secHit[i / SECTOR_WORDS])   mem[i] <= '0;
        if (strobe.eraseCommit && secHit[i / SECTOR_WORDS]) mem[i] <= '1;
      end
      if (rdStart) begin
        if (busy) begin
          dataOut <= {pollBit, toggle, {(DATA_W-2){1'b0}}};
          toggle  <= ~toggle;
        end else begin
          dataOut <= mem[rdIdx];
        end
      end
    end
  end
endmodule

// File: rtl/norCmdEngine.sv
module norCmdEngine
  import nfcPkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int SECTORS      = 4,
  parameter int SECTOR_WORDS = 16,
  parameter int PGM_CYC      = 8,
  parameter int PRE_CYC      = 6,
  parameter int ERS_CYC      = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ceN,
  input  logic               weN,
  input  logic               oeN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  dataIn,
  input  logic [SECTORS-1:0] protectMask,
  input  logic               lowSupply,
  output logic [DATA_W-1:0]  dataOut,
  output logic               ready
);
  localparam int IDX_W = $clog2(SECTORS * SECTOR_WORDS);

  logic wrStart, rdStart, busy, pollBit;
  nfcStrobe_t strobe;
  logic [IDX_W-1:0] opIdx;
  logic [DATA_W-1:0] opData;

  nfcBusSample uSample (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .wrStart(wrStart), .rdStart(rdStart)
  );

  nfcControl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECTORS(SECTORS), .SECTOR_WORDS(SECTOR_WORDS),
    .PGM_CYC(PGM_CYC), .PRE_CYC(PRE_CYC), .ERS_CYC(ERS_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .lowSupply(lowSupply),
    .addr(addr), .dataIn(dataIn), .protectMask(protectMask),
    .strobe(strobe), .opIdx(opIdx), .opData(opData), .busy(busy), .pollBit(pollBit)
  );

  nfcDatapath #(
    .DATA_W(DATA_W), .SECTORS(SECTORS), .SECTOR_WORDS(SECTOR_WORDS)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opIdx(opIdx), .opData(opData),
    .protectMask(protectMask), .busy(busy), .pollBit(pollBit),
    .rdStart(rdStart), .rdIdx(addr[IDX_W-1:0]), .dataOut(dataOut)
  );

  assign ready = ~busy;
endmodule

// File: rtl/nfcChecker.sv
module nfcChecker
  import nfcPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SECTORS  = 4,
  parameter int BUSY_MAX = 26
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       ready,
  input logic                       lowSupply,
  input logic                       wrStart,
  input logic [$clog2(SECTORS)-1:0] addrSector,
  input logic [SECTORS-1:0]         protectMask,
  input ctlState_t                  ctlState,
  input logic [DATA_W-1:0]          opData
);
  logic [15:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)       busyRun <= '0;
    else if (!ready) busyRun <= busyRun + 1'b1;
    else             busyRun <= '0;
  end

  // R9
  low_supply_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lowSupply && ready) |=> ready);

  // R3
  busy_from_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> $past(wrStart));

  // R3
  busy_bounded_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= 16'(BUSY_MAX));

  // R8
  protected_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStart && ctlState == ST_PGMDATA && protectMask[addrSector]) |=> ready);

  // R11
  busy_operand_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> $stable(opData));
endmodule

bind norCmdEngine nfcChecker #(
  .DATA_W(DATA_W), .SECTORS(SECTORS), .BUSY_MAX(PGM_CYC + PRE_CYC + ERS_CYC)
) uChk (
  .clk(clk), .rstN(rstN), .ready(ready), .lowSupply(lowSupply), .wrStart(wrStart),
  .addrSector(addr[$clog2(SECTORS*SECTOR_WORDS)-1 -: $clog2(SECTORS)]),
  .protectMask(protectMask), .ctlState(uCtrl.state), .opData(uCtrl.opData)
);

// File: tb/tb_norCmdEngine.sv
module tb_norCmdEngine;
  localparam int PGM = 8, PRE = 6, ERS = 12;
  localparam int WORDS = 64, SW = 16;

  logic clk = 0, rstN = 0, ceN = 1, weN = 1, oeN = 1, lowSupply = 0;
  logic [11:0] addr = '0;
  logic [7:0] dataIn = '0, dataOut;
  logic [3:0] protectMask = 4'b1000;
  logic ready;
  logic [7:0] model [WORDS];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  norCmdEngine #(.PGM_CYC(PGM), .PRE_CYC(PRE), .ERS_CYC(ERS)) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .dataIn(dataIn), .protectMask(protectMask), .lowSupply(lowSupply),
    .dataOut(dataOut), .ready(ready));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); ceN = 0; weN = 0; oeN = 1; addr = a; dataIn = d;
    @(negedge clk); ceN = 1; weN = 1;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); ceN = 0; oeN = 0; weN = 1; addr = a;
    @(negedge clk); d = dataOut; ceN = 1; oeN = 1;
  endtask

  task automatic busyLen(output int n);
    n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic unlock();
    busWrite(12'h555, 8'hAA); busWrite(12'h2AA, 8'h55);
  endtask

  task automatic program4(input logic [11:0] a, input logic [7:0] d);
    unlock(); busWrite(12'h555, 8'hA0); busWrite(a, d);
  endtask

  task automatic eraseSeq(input logic [11:0] a);
    unlock(); busWrite(12'h555, 8'h80); unlock(); busWrite(a, 8'h30);
  endtask

  function automatic logic [7:0] progModel(input logic [7:0] old, input logic [7:0] d);
    return old & d;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, r2;
    int n;
    void'($urandom(32'd2024));
    for (int i = 0; i < WORDS; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 ready", ready, 1);
    busRead(12'h000, r); check("R1 word0", r, 8'hFF);
    busRead(12'h03F, r); check("R1 word63", r, 8'hFF);

    // R2/R3 program and busy length
    program4(12'h005, 8'h3C);
    check("R3 ready low at accept", ready, 0);
    busyLen(n); check("R3 program busy cycles", n, PGM);
    model[5] = progModel(model[5], 8'h3C);
    busRead(12'h005, r); check("R2 program", r, model[5]);
    program4(12'h005, 8'hF0); busyLen(n);
    model[5] = progModel(model[5], 8'hF0);
    busRead(12'h005, r); check("R2 AND of old and new", r, 8'h30);

    // R4/R5 status reads during program
    program4(12'h009, 8'h80);
    busRead(12'h009, r); busRead(12'h009, r2);
    check("R4 poll bit", r[7], 0);
    check("R4 poll bit second", r2[7], 0);
    check("R5 toggle alternates", r[6] ^ r2[6], 1);
    busyLen(n); model[9] = 8'h80;
    busRead(12'h009, r); busRead(12'h009, r2);
    check("R4 true data after", r, 8'h80);
    check("R5 stable after", r2, r);
    program4(12'h00A, 8'h0F);
    busRead(12'h00A, r); check("R4 complement bit7", r[7], 1);

    // R11 writes while busy ignored
    unlock(); busWrite(12'h555, 8'hA0);
    busyLen(n); model[10] = 8'h0F;
    busWrite(12'h00B, 8'h00);
    check("R11 no new op", ready, 1);
    busRead(12'h00B, r); check("R11 word11 untouched", r, 8'hFF);
    busRead(12'h00A, r); check("R11 first op stored", r, 8'h0F);

    // R6 sector erase
    program4(12'h011, 8'h55); busyLen(n); model[17] = 8'h55;
    eraseSeq(12'h010);
    busyLen(n); check("R3 erase busy cycles", n, PRE + ERS);
    for (int i = 16; i < 32; i++) model[i] = 8'hFF;
    busRead(12'h011, r); check("R6 erased word", r, 8'hFF);
    busRead(12'h01F, r); check("R6 erased last word", r, 8'hFF);
    busRead(12'h005, r); check("R6 other sector kept", r, model[5]);
    eraseSeq(12'h015);
    busRead(12'h015, r); check("R4 erase poll bit", r[7], 0);
    busyLen(n);

    // R8 protection
    program4(12'h032, 8'h00);
    check("R8 program no busy", ready, 1);
    busRead(12'h032, r); check("R8 protected word", r, 8'hFF);
    eraseSeq(12'h030);
    check("R8 erase no busy", ready, 1);

    // R9 low supply
    lowSupply = 1;
    program4(12'h014, 8'h00);
    check("R9 no busy", ready, 1);
    lowSupply = 0;
    busRead(12'h014, r); check("R9 word unchanged", r, 8'hFF);

    // R7 bypass
    unlock(); busWrite(12'h555, 8'h20);
    busWrite(12'h000, 8'hA0); busWrite(12'h021, 8'h12);
    busyLen(n); check("R7 bypass busy cycles", n, PGM); model[33] = 8'h12;
    busRead(12'h021, r); check("R7 bypass program", r, 8'h12);
    busWrite(12'h000, 8'hA0); busWrite(12'h022, 8'h34); busyLen(n); model[34] = 8'h34;
    busRead(12'h022, r); check("R7 second bypass program", r, 8'h34);
    busWrite(12'h000, 8'h90); busWrite(12'h000, 8'h00);
    busWrite(12'h000, 8'hA0); busWrite(12'h023, 8'h00);
    check("R7 after exit no busy", ready, 1);
    busRead(12'h023, r); check("R7 after exit unchanged", r, 8'hFF);

    // R10 aborts
    unlock(); busWrite(12'h123, 8'h77); busWrite(12'h555, 8'hA0); busWrite(12'h024, 8'h00);
    busRead(12'h024, r); check("R10 junk aborts", r, 8'hFF);
    busWrite(12'h555, 8'hAA); busWrite(12'h000, 8'hF0);
    busWrite(12'h2AA, 8'h55); busWrite(12'h555, 8'hA0); busWrite(12'h025, 8'h00);
    check("R10 reset no busy", ready, 1);
    busRead(12'h025, r); check("R10 reset aborts", r, 8'hFF);

    // R2 constrained random programs on unprotected sectors
    for (int k = 0; k < 40; k++) begin
      int a, b;
      logic [7:0] d;
      a = $urandom_range(0, 47);
      b = $urandom_range(0, 47);
      d = 8'($urandom);
      program4(12'(a), d); busyLen(n);
      model[a] = progModel(model[a], d);
      busRead(12'(a), r); check("R2 random target", r, model[a]);
      busRead(12'(b), r); check("R2 random other", r, model[b]);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule